// File: doc/BRIEF.md
# Register-Loaded Two-Wire Bus Master

This block is a two-wire (I2C) bus master for a sensor-control path. A host presents a transfer on plain input fields: a 7-bit target ID, a speed select, a read/write choice, a 3-bit byte count, an 8-bit register index and an eight-byte write buffer. It then pulses `start_i`. The block takes a copy of all of these on that edge and runs the whole bus transaction on its own. `ready_o` and `err_o` report progress. A returned byte appears on `rd_data_o`.

A write sends the target ID with the direction bit clear, then the register index, then one to eight data bytes, and closes with a stop. A read always runs in two parts. The first part is a dummy write that carries only the register index and ends with its own stop. The second part is a new start, the ID with the direction bit set, and a single byte from the target. The master does not acknowledge that byte, and then sends a stop.

Both bus lines are open-drain. The block only asserts an output-enable that pulls a line low. It never drives a line high.

Top module: `i2c_reg_master`

## Requirements
- R1: After reset, `ready_o` is 1, `err_o` is 0, and both `scl_oe_o` and `sda_oe_o` are 0 (lines released).
- R2: A write runs in this order: start, then `{slave_id_i, 0}`, then `sub_addr_i`, then the data bytes, then stop. Each byte is sent MSB first and is followed by one acknowledge bit that the target drives.
- R3: A write sends `byte_cnt_i + 1` data bytes, so 1 to 8 bytes. Data byte k is `wr_data_i[8k+7:8k]`.
- R4: A read does a dummy write of `{slave_id_i, 0}` and `sub_addr_i`, then stop. It then sends start and `{slave_id_i, 1}` and receives one byte. The master leaves SDA released in the acknowledge slot of that byte (no acknowledge) and then sends stop. The received byte is held on `rd_data_o` and does not change while the block is idle.
- R5: A `start_i` pulse seen while `ready_o` is 1 makes `ready_o` go to 0 on the next cycle. `ready_o` stays 0 until the final stop is complete. A `start_i` pulse seen while `ready_o` is 0 is ignored.
- R6: If the target does not acknowledge any byte, `err_o` goes to 1 and no further bytes are sent. The block issues a stop and returns to ready. After a failed dummy write, no read part is started. `err_o` holds its value while the block is idle and is cleared when the next transfer is accepted.
- R7: The length of a data or acknowledge bit's SCL high time, in clock cycles, depends on the speed select. It is `2*QTR_FAST` when `fast_i` is 1 and `2*QTR_SLOW` when `fast_i` is 0.
- R8: Both lines are driven only low, through `scl_oe_o` and `sda_oe_o`. Both are 0 whenever `ready_o` is 1.
- R9: `scl_oe_o` and `sda_oe_o` never change in the same cycle. SDA changes while SCL is high only to form a start or a stop. A write therefore shows exactly one start and one stop, and a completed read shows exactly two of each.
- R10: All transfer fields are captured when `start_i` is accepted. Changes on those fields during a transfer have no effect on that transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Pulse that launches a transfer when ready |
| slave_id_i | input | 7 | Target device ID |
| fast_i | input | 1 | 1 selects the fast bit rate, 0 the slow rate |
| rd_mode_i | input | 1 | 1 selects a read, 0 a write |
| byte_cnt_i | input | 3 | Number of write data bytes minus one |
| sub_addr_i | input | 8 | Register index inside the target |
| wr_data_i | input | 64 | Write buffer; byte k at bits 8k+7:8k |
| sda_i | input | 1 | Sampled level of the SDA line |
| scl_oe_o | output | 1 | 1 pulls SCL low |
| sda_oe_o | output | 1 | 1 pulls SDA low |
| ready_o | output | 1 | 1 when idle, 0 while a transfer runs |
| err_o | output | 1 | 1 when the last transfer missed an acknowledge |
| rd_data_o | output | 8 | Byte returned by the last read |

## Verification
The hardest cases to reach are failures partway through a transfer. Examples are a target that acknowledges its ID but rejects the third byte, and a read whose dummy write fails at the register index, where the second part must not start. The bench models the target as a line-level device. Each table row tells the model at which byte position, counted from the last start, it should withhold one acknowledge. Rows with a wrong ID make the rejection happen at the address byte. Start and stop counts and the bytes the model stores then show exactly where the master stopped.

// File: rtl/i2cm_pkg.sv
package i2cm_pkg;
  typedef enum logic [1:0] {CMD_START, CMD_STOP, CMD_WR, CMD_RD} bit_cmd_e;
  typedef enum logic [2:0] {ST_IDLE, ST_START, ST_TX, ST_ACK, ST_RX, ST_MNACK, ST_STOP} ctl_state_e;
  typedef enum logic [1:0] {SG_ADDR_W, SG_SUB, SG_DATA, SG_ADDR_R} seg_e;
endpackage

// File: rtl/i2cm_qtr_div.sv
module i2cm_qtr_div #(
  parameter int unsigned QTR_SLOW = 312,
  parameter int unsigned QTR_FAST = 78
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic fast_i,
  output logic tick_o
);
  localparam int unsigned QMAX = (QTR_SLOW > QTR_FAST) ? QTR_SLOW : QTR_FAST;
  localparam int unsigned CW   = $clog2(QMAX + 1);
  localparam logic [CW-1:0] LIM_S = CW'(QTR_SLOW - 1);
  localparam logic [CW-1:0] LIM_F = CW'(QTR_FAST - 1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] lim;

  assign lim    = fast_i ? LIM_F : LIM_S;
  assign tick_o = run_i && (cnt_q == lim);

  // restarts with every bit command so each quarter is exact
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               cnt_q <= '0;
    else if (!run_i || tick_o) cnt_q <= '0;
    else                       cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/i2cm_bit_phy.sv
module i2cm_bit_phy
  import i2cm_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     tick_i,
  input  logic     cmd_vld_i,
  input  bit_cmd_e cmd_i,
  input  logic     wbit_i,
  input  logic     sda_i,
  output logic     busy_o,
  output logic     done_o,
  output logic     rbit_o,
  output logic     scl_oe_o,
  output logic     sda_oe_o
);
  logic       busy_q, done_q, rbit_q, wbit_q, scl_lo_q, sda_lo_q;
  logic [1:0] ph_q;
  logic [1:0] sda_sync_q;
  bit_cmd_e   cmd_q;

  // {scl_low, sda_low} per quarter phase
  function automatic logic [1:0] drive(bit_cmd_e c, logic [1:0] ph, logic b);
    logic scl_lo;
    scl_lo = (ph == 2'd0) || (ph == 2'd3);
    case (c)
      CMD_START: drive = {ph == 2'd3, ph != 2'd0};
      CMD_STOP:  drive = {ph == 2'd0, ph <= 2'd1};
      CMD_WR:    drive = {scl_lo, ~b};
      default:   drive = {scl_lo, 1'b0};
    endcase
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sda_sync_q <= 2'b11;
    else         sda_sync_q <= {sda_sync_q[0], sda_i};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q   <= 1'b0;
      done_q   <= 1'b0;
      rbit_q   <= 1'b1;
      wbit_q   <= 1'b1;
      ph_q     <= 2'd0;
      cmd_q    <= CMD_STOP;
      scl_lo_q <= 1'b0;
      sda_lo_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (!busy_q) begin
        if (cmd_vld_i) begin
          busy_q <= 1'b1;
          ph_q   <= 2'd0;
          cmd_q  <= cmd_i;
          wbit_q <= wbit_i;
          {scl_lo_q, sda_lo_q} <= drive(cmd_i, 2'd0, wbit_i);
        end
      end else if (tick_i) begin
        if (ph_q == 2'd2) rbit_q <= sda_sync_q[1];  // end of SCL high
        if (ph_q == 2'd3) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end else begin
          ph_q <= ph_q + 2'd1;
          {scl_lo_q, sda_lo_q} <= drive(cmd_q, ph_q + 2'd1, wbit_q);
        end
      end
    end
  end

  assign busy_o   = busy_q;
  assign done_o   = done_q;
  assign rbit_o   = rbit_q;
  assign scl_oe_o = scl_lo_q;
  assign sda_oe_o = sda_lo_q;
endmodule

// File: rtl/i2c_reg_master.sv
module i2c_reg_master
  import i2cm_pkg::*;
#(
  parameter int unsigned QTR_SLOW  = 312,
  parameter int unsigned QTR_FAST  = 78,
  parameter int unsigned MAX_BYTES = 8
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          start_i,
  input  logic [6:0]                    slave_id_i,
  input  logic                          fast_i,
  input  logic                          rd_mode_i,
  input  logic [$clog2(MAX_BYTES)-1:0]  byte_cnt_i,
  input  logic [8*MAX_BYTES-1:0]        wr_data_i,
  input  logic [7:0]                    sub_addr_i,
  input  logic                          sda_i,
  output logic                          scl_oe_o,
  output logic                          sda_oe_o,
  output logic                          ready_o,
  output logic                          err_o,
  output logic [7:0]                    rd_data_o
);
  localparam int unsigned CNT_W = $clog2(MAX_BYTES);
  localparam int unsigned BUF_W = 8 * MAX_BYTES;

  ctl_state_e       state_q;
  seg_e             seg_q;
  logic             rd_phase_q, wait_q, err_q;
  logic [7:0]       sh_q, rdata_q, sub_q;
  logic [2:0]       bit_idx_q;
  logic [CNT_W-1:0] byte_q, cnt_q, byte_nxt;
  logic [6:0]       sid_q;
  logic             fast_q, rd_q;
  logic [BUF_W-1:0] buf_q;

  logic     cmd_vld, wbit, tick, busy, done, rbit;
  bit_cmd_e cmd;

  assign byte_nxt = byte_q + 1'b1;
  assign cmd_vld  = (state_q != ST_IDLE) && !wait_q;
  assign wbit     = (state_q == ST_TX) ? sh_q[7] : 1'b1;

  always_comb begin
    case (state_q)
      ST_START: cmd = CMD_START;
      ST_TX:    cmd = CMD_WR;
      ST_ACK:   cmd = CMD_RD;
      ST_RX:    cmd = CMD_RD;
      ST_MNACK: cmd = CMD_WR;
      default:  cmd = CMD_STOP;
    endcase
  end

  i2cm_qtr_div #(.QTR_SLOW(QTR_SLOW), .QTR_FAST(QTR_FAST)) div_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .run_i(busy), .fast_i(fast_q), .tick_o(tick)
  );

  i2cm_bit_phy phy_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick), .cmd_vld_i(cmd_vld), .cmd_i(cmd),
    .wbit_i(wbit), .sda_i(sda_i), .busy_o(busy), .done_o(done), .rbit_o(rbit),
    .scl_oe_o(scl_oe_o), .sda_oe_o(sda_oe_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      seg_q      <= SG_ADDR_W;
      rd_phase_q <= 1'b0;
      wait_q     <= 1'b0;
      err_q      <= 1'b0;
      sh_q       <= '0;
      rdata_q    <= '0;
      sub_q      <= '0;
      bit_idx_q  <= '0;
      byte_q     <= '0;
      cnt_q      <= '0;
      sid_q      <= '0;
      fast_q     <= 1'b0;
      rd_q       <= 1'b0;
      buf_q      <= '0;
    end else if (state_q == ST_IDLE) begin
      if (start_i) begin
        sid_q      <= slave_id_i;
        fast_q     <= fast_i;
        rd_q       <= rd_mode_i;
        cnt_q      <= byte_cnt_i;
        sub_q      <= sub_addr_i;
        buf_q      <= wr_data_i;
        err_q      <= 1'b0;
        rd_phase_q <= 1'b0;
        wait_q     <= 1'b0;
        state_q    <= ST_START;
      end
    end else begin
      if (cmd_vld) wait_q <= 1'b1;
      if (done) begin
        wait_q <= 1'b0;
        case (state_q)
          ST_START: begin
            sh_q      <= {sid_q, rd_phase_q};
            seg_q     <= rd_phase_q ? SG_ADDR_R : SG_ADDR_W;
            bit_idx_q <= 3'd7;
            state_q   <= ST_TX;
          end
          ST_TX: begin
            if (bit_idx_q == 3'd0) state_q <= ST_ACK;
            else begin
              sh_q      <= {sh_q[6:0], 1'b0};
              bit_idx_q <= bit_idx_q - 3'd1;
            end
          end
          ST_ACK: begin
            bit_idx_q <= 3'd7;
            if (rbit) begin
              err_q   <= 1'b1;
              state_q <= ST_STOP;
            end else begin
              case (seg_q)
                SG_ADDR_W: begin
                  sh_q    <= sub_q;
                  seg_q   <= SG_SUB;
                  state_q <= ST_TX;
                end
                SG_SUB: begin
                  if (rd_q) state_q <= ST_STOP;
                  else begin
                    byte_q  <= '0;
                    sh_q    <= buf_q[7:0];
                    seg_q   <= SG_DATA;
                    state_q <= ST_TX;
                  end
                end
                SG_DATA: begin
                  if (byte_q == cnt_q) state_q <= ST_STOP;
                  else begin
                    byte_q  <= byte_nxt;
                    sh_q    <= buf_q[8*byte_nxt +: 8];
                    state_q <= ST_TX;
                  end
                end
                default: state_q <= ST_RX;
              endcase
            end
          end
          ST_RX: begin
            rdata_q <= {rdata_q[6:0], rbit};
            if (bit_idx_q == 3'd0) state_q <= ST_MNACK;
            else bit_idx_q <= bit_idx_q - 3'd1;
          end
          ST_MNACK: state_q <= ST_STOP;
          default: begin
            // dummy write done: launch the read part
            if (rd_q && !rd_phase_q && !err_q) begin
              rd_phase_q <= 1'b1;
              state_q    <= ST_START;
            end else state_q <= ST_IDLE;
          end
        endcase
      end
    end
  end

  assign ready_o   = (state_q == ST_IDLE);
  assign err_o     = err_q;
  assign rd_data_o = rdata_q;
endmodule

// File: rtl/i2c_reg_master_chk.sv
module i2c_reg_master_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       start_i,
  input logic       ready_o,
  input logic       err_o,
  input logic [7:0] rd_data_o,
  input logic       scl_oe_o,
  input logic       sda_oe_o
);
  // R8
  idle_bus_released_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |-> (!scl_oe_o && !sda_oe_o));

  // R5
  start_goes_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready_o && start_i) |=> !ready_o);

  // R6
  err_held_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready_o && $past(ready_o)) |-> $stable(err_o));

  // R4
  rd_data_held_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready_o && $past(ready_o)) |-> $stable(rd_data_o));

  // R9
  lines_not_together_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(scl_oe_o) |-> $stable(sda_oe_o));
endmodule

bind i2c_reg_master i2c_reg_master_chk chk_i (
  .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .ready_o(ready_o), .err_o(err_o),
  .rd_data_o(rd_data_o), .scl_oe_o(scl_oe_o), .sda_oe_o(sda_oe_o)
);

// File: tb/i2c_reg_master_tb_top.sv
module i2c_reg_master_tb_top;
  localparam int QS = 8;
  localparam int QF = 2;
  localparam logic [6:0] SLV = 7'h42;
  localparam int NV = 11;

  typedef struct packed {
    logic        rd;
    logic        fast;
    logic [2:0]  cnt;
    logic [6:0]  sid;
    logic [7:0]  sub;
    logic [63:0] data;
    logic [3:0]  nack_at;   // byte position since last start, F = none
    logic        exp_err;
  } vec_t;

  localparam vec_t VECS [NV] = '{
    '{1'b0, 1'b1, 3'd0, SLV,   8'h10, 64'h0000_0000_0000_003C, 4'hF, 1'b0},
    '{1'b0, 1'b0, 3'd7, SLV,   8'h20, 64'h8877_6655_4433_2211, 4'hF, 1'b0},
    '{1'b0, 1'b1, 3'd3, SLV,   8'hFE, 64'h0000_0000_DDCC_BBAA, 4'hF, 1'b0},
    '{1'b1, 1'b1, 3'd0, SLV,   8'h20, 64'h0,                   4'hF, 1'b0},
    '{1'b1, 1'b0, 3'd0, SLV,   8'h10, 64'h0,                   4'hF, 1'b0},
    '{1'b1, 1'b1, 3'd5, SLV,   8'h01, 64'hFFFF,                4'hF, 1'b0},
    '{1'b0, 1'b1, 3'd2, SLV,   8'h30, 64'h0000_0000_00C3_B2A1, 4'd3, 1'b1},
    '{1'b1, 1'b1, 3'd0, SLV,   8'h40, 64'h0,                   4'd0, 1'b1},
    '{1'b0, 1'b0, 3'd1, 7'h11, 8'h50, 64'h0000_0000_0000_5A5A, 4'hF, 1'b1},
    '{1'b1, 1'b1, 3'd0, SLV,   8'h30, 64'h0,                   4'hF, 1'b0},
    '{1'b1, 1'b1, 3'd0, SLV,   8'h02, 64'h0,                   4'd1, 1'b1}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [6:0]  sid = '0;
  logic        fast = 1'b0;
  logic        rd = 1'b0;
  logic [2:0]  cnt = '0;
  logic [63:0] wdata = '0;
  logic [7:0]  sub = '0;
  logic        scl_oe, sda_oe, ready, err;
  logic [7:0]  rdata;
  logic        sl_pull = 1'b0;
  logic        sda_bus;

  assign sda_bus = ~(sda_oe | sl_pull);

  always #4 clk = ~clk;

  i2c_reg_master #(.QTR_SLOW(QS), .QTR_FAST(QF), .MAX_BYTES(8)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .slave_id_i(sid), .fast_i(fast),
    .rd_mode_i(rd), .byte_cnt_i(cnt), .wr_data_i(wdata), .sub_addr_i(sub),
    .sda_i(sda_bus), .scl_oe_o(scl_oe), .sda_oe_o(sda_oe), .ready_o(ready),
    .err_o(err), .rd_data_o(rdata)
  );

  // ---------------- line-level target model ----------------
  logic [7:0] mem [256];
  logic [7:0] ref_mem [256];
  int   n_start = 0, n_stop = 0, n_wr = 0, hi_last = 0, hi_cnt = 0;
  int   bitn = 0, byteno = 0;
  logic prev_scl = 1'b1, prev_sda = 1'b1, active = 1'b0, sending = 1'b0;
  logic ack_q = 1'b0, rw = 1'b0, mack = 1'b0, nack_armed = 1'b0;
  logic [3:0] nack_at = 4'hF;
  logic [7:0] sh = '0, tx = '0, ptr = '0;

  initial for (int i = 0; i < 256; i++) begin
    mem[i]     = 8'(i * 7 + 3);
    ref_mem[i] = 8'(i * 7 + 3);
  end

  always @(negedge clk) begin
    logic scl_now, sda_now, nk;
    scl_now = ~scl_oe;
    sda_now = ~(sda_oe | sl_pull);
    if (prev_scl && scl_now && prev_sda && !sda_now) begin
      n_start++; active = 1'b1; bitn = -1; byteno = 0; sending = 1'b0;
    end else if (prev_scl && scl_now && !prev_sda && sda_now) begin
      n_stop++; active = 1'b0; sl_pull = 1'b0;
    end
    if (!prev_scl && scl_now) begin
      hi_cnt = 0;
      if (active && bitn >= 0 && bitn < 8 && !sending) sh = {sh[6:0], sda_now};
      if (active && bitn == 8 && sending) mack = sda_now;
    end
    if (scl_now) hi_cnt++;
    if (prev_scl && !scl_now && active) begin
      if (bitn >= 0) hi_last = hi_cnt;
      if (bitn < 7) begin
        bitn++;
        if (sending && bitn > 0) begin
          tx = {tx[6:0], 1'b0};
          sl_pull = ~tx[7];
        end
      end else if (bitn == 7) begin
        bitn = 8;
        if (sending) sl_pull = 1'b0;
        else begin
          nk = nack_armed && (byteno == int'(nack_at));
          if (nk) nack_armed = 1'b0;
          if (byteno == 0) begin
            rw = sh[0];
            ack_q = (sh[7:1] == SLV) && !nk;
          end else if (byteno == 1) begin
            ack_q = !nk;
            if (!nk) ptr = sh;
          end else begin
            ack_q = !nk;
            if (!nk) begin mem[ptr] = sh; ptr++; n_wr++; end
          end
          sl_pull = ack_q;
        end
      end else begin
        sl_pull = 1'b0;
        bitn = 0;
        if (sending) sending = 1'b0;
        else if (!ack_q) active = 1'b0;
        else begin
          if (byteno == 0 && rw) begin
            sending = 1'b1; tx = mem[ptr]; sl_pull = ~tx[7];
          end
          byteno++;
        end
      end
    end
    prev_scl = scl_now;
    prev_sda = ~(sda_oe | sl_pull);
  end

  // ---------------- checking ----------------
  int tests = 0, fails = 0;
  logic done_flag = 1'b0;

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_ready(input string req);
    int n = 0;
    while (!ready && n < 20000) begin @(negedge clk); n++; end
    chk(ready, req, 0, 1);
  endtask

  task automatic launch(input vec_t v);
    @(negedge clk);
    rd = v.rd; fast = v.fast; cnt = v.cnt; sid = v.sid; sub = v.sub; wdata = v.data;
    nack_at = v.nack_at; nack_armed = (v.nack_at != 4'hF);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  initial begin
    int s0, p0, w0, n_ok, exp_starts;
    logic [7:0] exp_rd;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(ready == 1'b1, "R1 ready", ready, 1);
    chk(err == 1'b0, "R1 err", err, 0);
    chk(scl_oe == 1'b0 && sda_oe == 1'b0, "R1 lines", {scl_oe, sda_oe}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    for (int v = 0; v < NV; v++) begin
      vec_t cv;
      cv = VECS[v];
      s0 = n_start; p0 = n_stop; w0 = n_wr;
      exp_rd = ref_mem[cv.sub];
      launch(cv);
      chk(!ready, "R5 busy", ready, 0);
      wait_ready("R5 done");
      chk(err == cv.exp_err, "R6 err", err, cv.exp_err);
      n_ok = cv.exp_err ? ((cv.nack_at >= 4'd2 && cv.nack_at != 4'hF) ? int'(cv.nack_at) - 2 : 0)
                        : (cv.rd ? 0 : int'(cv.cnt) + 1);
      chk(n_wr - w0 == n_ok, "R3 byte count", n_wr - w0, n_ok);
      for (int k = 0; k < n_ok; k++) ref_mem[8'(cv.sub + k)] = cv.data[8*k +: 8];
      for (int k = 0; k <= 8; k++)
        chk(mem[8'(cv.sub + k)] == ref_mem[8'(cv.sub + k)], "R2 stored data",
            mem[8'(cv.sub + k)], ref_mem[8'(cv.sub + k)]);
      exp_starts = (cv.rd && (!cv.exp_err || cv.nack_at >= 4'd2)) ? 2 : 1;
      chk(n_start - s0 == exp_starts, "R9 starts", n_start - s0, exp_starts);
      chk(n_stop - p0 == exp_starts, "R9 stops", n_stop - p0, exp_starts);
      chk(hi_last == 2 * (cv.fast ? QF : QS), "R7 scl high", hi_last, 2 * (cv.fast ? QF : QS));
      if (cv.rd && !cv.exp_err) begin
        chk(rdata == exp_rd, "R4 read byte", rdata, exp_rd);
        chk(mack == 1'b1, "R4 master nack", mack, 1);
        repeat (20) @(negedge clk);
        chk(rdata == exp_rd, "R4 held", rdata, exp_rd);
      end
      if (cv.exp_err) begin
        repeat (20) @(negedge clk);
        chk(err == 1'b1, "R6 err held", err, 1);
      end
    end

    // R5 / R10: busy start ignored, fields captured at accept
    begin
      vec_t dv;
      dv = '{1'b0, 1'b1, 3'd1, SLV, 8'h60, 64'h0000_0000_0000_9F8E, 4'hF, 1'b0};
      s0 = n_start; w0 = n_wr;
      launch(dv);
      chk(err == 1'b0, "R6 err cleared", err, 0);
      repeat (10) @(negedge clk);
      wdata = 64'h1111; sub = 8'h70; rd = 1'b1; cnt = 3'd7;
      start = 1'b1; @(negedge clk); start = 1'b0;
      wait_ready("R5 done");
      chk(n_start - s0 == 1, "R5 busy start ignored", n_start - s0, 1);
      chk(n_wr - w0 == 2, "R10 count captured", n_wr - w0, 2);
      chk(mem[8'h60] == 8'h8E, "R10 data captured", mem[8'h60], 8'h8E);
      chk(mem[8'h61] == 8'h9F, "R3 byte1 order", mem[8'h61], 8'h9F);
      chk(mem[8'h70] == ref_mem[8'h70], "R10 sub captured", mem[8'h70], ref_mem[8'h70]);
      chk(scl_oe == 1'b0 && sda_oe == 1'b0, "R8 idle released", {scl_oe, sda_oe}, 0);
    end
    done_flag = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(negedge clk);
    if (!done_flag) begin
      tests++; fails++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule